// File: doc/BRIEF.md
# Operand Effective Address Unit

This unit turns the addressing information of one instruction operand into a final operand location. A request presents a mode code, the values of up to two general registers, a 16-bit signed constant from the instruction word, the already advanced program counter, a full-width absolute address field and an operand size code. One result comes back. It holds the effective address and two flags: one saying the operand is the constant itself, one saying the operand is a register's content. For the stepping modes it also carries a register update to write back.

Every mode except memory-indirect is resolved in the next cycle. Memory-indirect fetches a pointer word through a valid/ready read port, and the word that comes back becomes the effective address. The controller is a three-state machine: `IDLE`, `PTR_READ` and `RESULT`. `IDLE` goes to `RESULT` when it accepts a direct mode and to `PTR_READ` when it accepts the memory-indirect mode. `PTR_READ` stays put until the read handshake completes and then goes to `RESULT`. `RESULT` always returns to `IDLE` after one cycle. A request is accepted only in `IDLE`.

Top module: `ea_unit`

## Requirements
- R1: After reset `res_valid`, `rd_valid` and `busy` are all low.
- R2: Mode 0 (register) yields `is_reg`=1, `ea`=0, `is_imm`=0, `wb_en`=0. At most one of `is_imm`, `is_reg`, `wb_en` is high with any result.
- R3: Mode 1 (immediate) yields `is_imm`=1 and `ea` equal to `x_val` sign-extended from bit 15.
- R4: Mode 2 (absolute) yields `ea`=`abs_addr`. Mode 3 (register-indirect) yields `ea`=`ri_val`.
- R5: Mode 5 (indexed) yields `ea` = sext(`x_val`) + `ri_val`, and mode 8 (PC-relative) yields `ea` = sext(`x_val`) + `pc_val`. Both sums wrap modulo 2^32, and neither mode requests a register update.
- R6: Mode 6 (two-register) yields `ea` = `ri_val` + `rj_val`. Mode 7 (two-register plus offset) yields `ea` = sext(`x_val`) + `ri_val` + `rj_val`. Both sums wrap modulo 2^32.
- R7: Mode 9 (post-increment) yields `ea`=`ri_val`, `wb_en`=1 and `wb_data`=`ri_val`+step. The step is 1, 2 or 4 for `size_code` 0, 1 or 2, and 4 for code 3.
- R8: Mode 10 (pre-decrement) yields `ea` = `wb_data` = `ri_val` − step (wrapping, same step rule as R7) with `wb_en`=1.
- R9: `wb_en` is high only in a cycle where `res_valid` is high, and only for modes 9 and 10.
- R10: Mode 4 (memory-indirect) raises `rd_valid` the cycle after acceptance with `rd_addr`=`abs_addr`. Both hold steady until `rd_ready`. `res_valid` follows one cycle after the handshake, with `ea` equal to the `rd_data` taken at the handshake and all flags low.
- R11: For other modes `res_valid` pulses for exactly one cycle, one cycle after `start` is accepted. `start` while `busy` is high is ignored.
- R12: Mode codes 11 to 15 yield a result with `ea`=0 and all flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken only when idle |
| mode | input | 4 | Addressing mode code |
| ri_val | input | 32 | First register value |
| rj_val | input | 32 | Second register value |
| x_val | input | 16 | Signed instruction constant |
| pc_val | input | 32 | Advanced program counter |
| abs_addr | input | 32 | Absolute address field |
| size_code | input | 2 | Operand size code |
| busy | output | 1 | Request in flight |
| res_valid | output | 1 | Result strobe |
| ea | output | 32 | Effective address or immediate value |
| is_imm | output | 1 | Operand is the constant |
| is_reg | output | 1 | Operand is a register |
| wb_en | output | 1 | Register update enable |
| wb_data | output | 32 | Register update value |
| rd_valid | output | 1 | Pointer read request |
| rd_addr | output | 32 | Pointer read address |
| rd_ready | input | 1 | Memory accepts read; data valid |
| rd_data | input | 32 | Pointer word |

## Verification
The bench drives negative constants and register values near the top of the address space. A unit that zero-extends the constant, or that fails to wrap, returns an address off by 2^16 or one that has overflowed. Every size code is sent through both stepping modes, including the reserved code 3 and a decrement below zero, to catch a wrong step or a step applied to the wrong side of the address. Memory-indirect is run with an immediate response and with a delayed one. During the delay the bench changes the address field and pulses `start` again, so a unit that reloads its read address or accepts the second request shows up as a wrong `rd_addr` or an extra result.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int EA_AW = 32;
    localparam int EA_XW = 16;

    localparam logic [3:0] MD_REG     = 4'd0;
    localparam logic [3:0] MD_IMM     = 4'd1;
    localparam logic [3:0] MD_ABS     = 4'd2;
    localparam logic [3:0] MD_REGIND  = 4'd3;
    localparam logic [3:0] MD_MEMIND  = 4'd4;
    localparam logic [3:0] MD_INDEX   = 4'd5;
    localparam logic [3:0] MD_TWOREG  = 4'd6;
    localparam logic [3:0] MD_TWOOFS  = 4'd7;
    localparam logic [3:0] MD_PCREL   = 4'd8;
    localparam logic [3:0] MD_POSTINC = 4'd9;
    localparam logic [3:0] MD_PREDEC  = 4'd10;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PTR_READ = 2'd1,
        ST_RESULT   = 2'd2
    } ea_state_e;
endpackage

// File: rtl/ea_step.sv
module ea_step #(
    parameter int AW = 32
) (
    input  logic [1:0]    size_code,
    output logic [AW-1:0] step
);
    localparam logic [AW-1:0] STEP_B = AW'(1);
    localparam logic [AW-1:0] STEP_H = AW'(2);
    localparam logic [AW-1:0] STEP_W = AW'(4);

    always_comb begin
        unique case (size_code)
            2'd0:    step = STEP_B;
            2'd1:    step = STEP_H;
            default: step = STEP_W;
        endcase
    end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int AW = 32,
    parameter int XW = 16
) (
    input  logic [3:0]    mode,
    input  logic [AW-1:0] ri_val,
    input  logic [AW-1:0] rj_val,
    input  logic [XW-1:0] x_val,
    input  logic [AW-1:0] pc_val,
    input  logic [AW-1:0] abs_addr,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] ea,
    output logic          is_imm,
    output logic          is_reg,
    output logic          wb_en,
    output logic [AW-1:0] wb_data,
    output logic          needs_ptr
);
    logic [AW-1:0] x_ext;
    logic [AW-1:0] dec_val;

    generate
        if (AW > XW) begin : g_sext
            assign x_ext = {{(AW-XW){x_val[XW-1]}}, x_val};
        end else begin : g_trunc
            assign x_ext = x_val[AW-1:0];
        end
    endgenerate

    assign dec_val = ri_val - step;

    always_comb begin
        ea        = '0;
        is_imm    = 1'b0;
        is_reg    = 1'b0;
        wb_en     = 1'b0;
        wb_data   = '0;
        needs_ptr = 1'b0;
        unique case (mode)
            MD_REG:     is_reg = 1'b1;
            MD_IMM:     begin ea = x_ext; is_imm = 1'b1; end
            MD_ABS:     ea = abs_addr;
            MD_REGIND:  ea = ri_val;
            MD_MEMIND:  needs_ptr = 1'b1;
            MD_INDEX:   ea = x_ext + ri_val;
            MD_TWOREG:  ea = ri_val + rj_val;
            MD_TWOOFS:  ea = x_ext + ri_val + rj_val;
            MD_PCREL:   ea = x_ext + pc_val;
            MD_POSTINC: begin ea = ri_val;  wb_en = 1'b1; wb_data = ri_val + step; end
            MD_PREDEC:  begin ea = dec_val; wb_en = 1'b1; wb_data = dec_val; end
            default:    ea = '0;
        endcase
    end
endmodule

// File: rtl/ea_fsm.sv
module ea_fsm
    import ea_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic needs_ptr,
    input  logic rd_ready,
    output logic accept,
    output logic ptr_take,
    output logic busy,
    output logic rd_valid,
    output logic res_valid
);
    ea_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start) state_d = needs_ptr ? ST_PTR_READ : ST_RESULT;
            ST_PTR_READ: if (rd_ready) state_d = ST_RESULT;
            ST_RESULT:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        ptr_take  = 1'b0;
        busy      = 1'b1;
        rd_valid  = 1'b0;
        res_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:     begin busy = 1'b0; accept = start; end
            ST_PTR_READ: begin rd_valid = 1'b1; ptr_take = rd_ready; end
            ST_RESULT:   res_valid = 1'b1;
            default:     busy = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW = EA_AW,
    parameter int XW = EA_XW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [AW-1:0] ri_val,
    input  logic [AW-1:0] rj_val,
    input  logic [XW-1:0] x_val,
    input  logic [AW-1:0] pc_val,
    input  logic [AW-1:0] abs_addr,
    input  logic [1:0]    size_code,
    output logic          busy,
    output logic          res_valid,
    output logic [AW-1:0] ea,
    output logic          is_imm,
    output logic          is_reg,
    output logic          wb_en,
    output logic [AW-1:0] wb_data,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ready,
    input  logic [AW-1:0] rd_data
);
    logic [AW-1:0] step;
    logic [AW-1:0] c_ea, c_wbd;
    logic          c_imm, c_reg, c_wb, c_ptr;
    logic          accept, ptr_take;

    logic [AW-1:0] ea_q, wbd_q, rda_q;
    logic          imm_q, reg_q, wb_q;

    ea_step #(.AW(AW)) u_step (
        .size_code (size_code),
        .step      (step)
    );

    ea_calc #(.AW(AW), .XW(XW)) u_calc (
        .mode      (mode),
        .ri_val    (ri_val),
        .rj_val    (rj_val),
        .x_val     (x_val),
        .pc_val    (pc_val),
        .abs_addr  (abs_addr),
        .step      (step),
        .ea        (c_ea),
        .is_imm    (c_imm),
        .is_reg    (c_reg),
        .wb_en     (c_wb),
        .wb_data   (c_wbd),
        .needs_ptr (c_ptr)
    );

    ea_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .needs_ptr (c_ptr),
        .rd_ready  (rd_ready),
        .accept    (accept),
        .ptr_take  (ptr_take),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .res_valid (res_valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q  <= '0;
            wbd_q <= '0;
            rda_q <= '0;
            imm_q <= 1'b0;
            reg_q <= 1'b0;
            wb_q  <= 1'b0;
        end else if (accept) begin
            ea_q  <= c_ea;
            wbd_q <= c_wbd;
            rda_q <= abs_addr;
            imm_q <= c_imm;
            reg_q <= c_reg;
            wb_q  <= c_wb;
        end else if (ptr_take) begin
            ea_q  <= rd_data;
        end
    end

    assign ea      = ea_q;
    assign is_imm  = imm_q;
    assign is_reg  = reg_q;
    assign wb_en   = res_valid & wb_q;
    assign wb_data = wbd_q;
    assign rd_addr = rda_q;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          res_valid,
    input logic          is_imm,
    input logic          is_reg,
    input logic          wb_en,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [AW-1:0] rd_addr
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $onehot0({is_imm, is_reg, wb_en})); // R2

    AST_WB_WITH_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> res_valid); // R9

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R10

    AST_RES_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> res_valid); // R10

    AST_NO_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_valid); // R10

    AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R11

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R11
endmodule

bind ea_unit ea_unit_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .res_valid (res_valid),
    .is_imm    (is_imm),
    .is_reg    (is_reg),
    .wb_en     (wb_en),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_addr   (rd_addr)
);

// File: tb/ea_unit_tb_top.sv
module ea_unit_tb_top;
    typedef struct {
        logic [31:0] ea;
        logic        imm;
        logic        rg;
        logic        wb;
        logic [31:0] wbd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [31:0] ri_val = '0, rj_val = '0, pc_val = '0, abs_addr = '0;
    logic [15:0] x_val = '0;
    logic [1:0]  size_code = '0;
    logic        busy, res_valid, is_imm, is_reg, wb_en, rd_valid;
    logic [31:0] ea, wb_data, rd_addr;
    logic        rd_ready = 1'b0;
    logic [31:0] rd_data = '0;

    int   n_tests = 0;
    int   n_fail  = 0;
    int   mem_delay = 0;
    int   wcnt = 0;
    logic [31:0] exp_rd_addr = '0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    ea_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .ri_val(ri_val), .rj_val(rj_val), .x_val(x_val), .pc_val(pc_val),
        .abs_addr(abs_addr), .size_code(size_code), .busy(busy),
        .res_valid(res_valid), .ea(ea), .is_imm(is_imm), .is_reg(is_reg),
        .wb_en(wb_en), .wb_data(wb_data), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return a ^ 32'h5A5A_0F0F;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [3:0] m, input logic [31:0] ri, input logic [31:0] rj,
                                   input logic [15:0] x, input logic [31:0] pc, input logic [31:0] ab,
                                   input logic [1:0] sz);
        exp_t e;
        logic [31:0] xs, st;
        xs = {{16{x[15]}}, x};
        st = (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
        e.ea = '0; e.imm = 0; e.rg = 0; e.wb = 0; e.wbd = '0;
        case (m)
            4'd0:  begin e.rg = 1; e.tag = "R2"; end
            4'd1:  begin e.ea = xs; e.imm = 1; e.tag = "R3"; end
            4'd2:  begin e.ea = ab; e.tag = "R4"; end
            4'd3:  begin e.ea = ri; e.tag = "R4"; end
            4'd4:  begin e.ea = mem_word(ab); e.tag = "R10"; end
            4'd5:  begin e.ea = xs + ri; e.tag = "R5"; end
            4'd6:  begin e.ea = ri + rj; e.tag = "R6"; end
            4'd7:  begin e.ea = xs + ri + rj; e.tag = "R6"; end
            4'd8:  begin e.ea = xs + pc; e.tag = "R5"; end
            4'd9:  begin e.ea = ri; e.wb = 1; e.wbd = ri + st; e.tag = "R7"; end
            4'd10: begin e.ea = ri - st; e.wb = 1; e.wbd = ri - st; e.tag = "R8"; end
            default: e.tag = "R12";
        endcase
        return e;
    endfunction

    // memory responder for the pointer read (R10)
    always @(negedge clk) begin
        if (rd_ready) begin
            rd_ready = 1'b0;
        end else if (rd_valid) begin
            if (wcnt >= mem_delay) begin
                check("R10 rd_addr", rd_addr, exp_rd_addr);
                rd_data  = mem_word(rd_addr);
                rd_ready = 1'b1;
                wcnt = 0;
            end else begin
                wcnt++;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!res_valid && wb_en) check("R9 wb_en without result", 32'(wb_en), 32'd0);
            if (res_valid) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected result", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " ea"}, ea, e.ea);
                    check({e.tag, " is_imm"}, 32'(is_imm), 32'(e.imm));
                    check({e.tag, " is_reg"}, 32'(is_reg), 32'(e.rg));
                    check({e.tag, " R9 wb_en"}, 32'(wb_en), 32'(e.wb));
                    if (e.wb) check({e.tag, " wb_data"}, wb_data, e.wbd);
                end
            end
        end
    end

    task automatic issue(input logic [3:0] m, input logic [31:0] ri, input logic [31:0] rj,
                         input logic [15:0] x, input logic [31:0] pc, input logic [31:0] ab,
                         input logic [1:0] sz, input bit poke_busy);
        @(negedge clk);
        mode = m; ri_val = ri; rj_val = rj; x_val = x; pc_val = pc;
        abs_addr = ab; size_code = sz; start = 1'b1;
        exp_rd_addr = ab;
        exp_q.push_back(model(m, ri, rj, x, pc, ab, sz));
        @(negedge clk);
        if (poke_busy) begin
            // R11: start while busy must be ignored; address field changes too
            mode = 4'd0; abs_addr = ~ab; start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        while (busy) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 res_valid", 32'(res_valid), 32'd0);
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 busy", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        issue(4'd0, 32'h1234_5678, 0, 16'h0010, 0, 0, 2, 0);                 // R2
        issue(4'd1, 0, 0, 16'hFF80, 0, 0, 2, 0);                              // R3 negative
        issue(4'd1, 0, 0, 16'h7FFF, 0, 0, 2, 0);                              // R3 positive
        issue(4'd2, 32'h1, 0, 0, 0, 32'hCAFE_0100, 2, 0);                     // R4 absolute
        issue(4'd3, 32'h0000_4000, 0, 0, 0, 0, 2, 0);                         // R4 reg-indirect
        issue(4'd5, 32'h0000_1000, 0, 16'h0020, 0, 0, 2, 0);                  // R5 index
        issue(4'd5, 32'h0000_1000, 0, 16'hFFF0, 0, 0, 2, 0);                  // R5 negative X
        issue(4'd5, 32'hFFFF_FFF0, 0, 16'h0020, 0, 0, 2, 0);                  // R5 wrap
        issue(4'd8, 0, 0, 16'hFFFC, 32'h0000_0200, 0, 2, 0);                  // R5 relative
        issue(4'd6, 32'h8000_0000, 32'h8000_0010, 0, 0, 0, 2, 0);             // R6 wrap
        issue(4'd7, 32'h0000_0100, 32'h0000_0030, 16'h8000, 0, 0, 2, 0);      // R6 offset
        issue(4'd9, 32'h0000_0100, 0, 0, 0, 0, 0, 0);                         // R7 step 1
        issue(4'd9, 32'h0000_0100, 0, 0, 0, 0, 1, 0);                         // R7 step 2
        issue(4'd9, 32'h0000_0100, 0, 0, 0, 0, 2, 0);                         // R7 step 4
        issue(4'd9, 32'hFFFF_FFFE, 0, 0, 0, 0, 3, 0);                         // R7 code 3, wrap
        issue(4'd10, 32'h0000_0100, 0, 0, 0, 0, 1, 0);                        // R8 step 2
        issue(4'd10, 32'h0000_0002, 0, 0, 0, 0, 2, 0);                        // R8 wrap
        mem_delay = 0;
        issue(4'd4, 0, 0, 0, 0, 32'h0000_8000, 2, 0);                         // R10 fast
        mem_delay = 3;
        issue(4'd4, 0, 0, 0, 0, 32'h1357_9BDF, 2, 1);                         // R10, R11 busy poke
        issue(4'd12, 32'h5, 32'h6, 16'h7, 32'h8, 32'h9, 2, 0);                // R12
        issue(4'd15, 32'h5, 32'h6, 16'h7, 32'h8, 32'h9, 2, 0);                // R12

        repeat (4) @(negedge clk);
        check("R11 results outstanding", 32'(exp_q.size()), 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule